// File: doc/BRIEF.md
# Token-Passing Link Readout Sequencer

This block gathers one event from many front-end links into a single outgoing word stream. Each link has its own input FIFO. A token visits the links in ascending index order, starting at the lowest unmasked link for every event. The link that holds the token streams its words out until it delivers a trailer word. The token then passes to the next unmasked link. When the highest unmasked link delivers its trailer, the event is complete, and the token returns to the bottom for the next event. Because the links always appear in the same order and each FIFO preserves arrival order, events leave in the order they arrived.

Each incoming word carries a two-bit tag: 2'b01 marks a header, 2'b10 marks a trailer, and 2'b00 or 2'b11 mark data. If a link's part of an event does not begin with a header, that link is treated as a raw stream for the rest of that part. Every word it sends up to and including its trailer is marked with an error flag. A static per-link mask takes a link out of use. When the pairing mode is on and exactly one link of an aligned pair (2k, 2k+1) is masked, the unmasked link takes over both physical buffers and its depth doubles.

Each link input is a valid/ready stream; a word is accepted on a clock edge where both are high. The output is also a valid/ready stream. While `out_ready` is low, the output holds its word and all its side fields, and a word is consumed only on a cycle where `out_valid` and `out_ready` are both high. The mask and the pairing mode may change only while reset is held.

Top module: `tpr_link_sequencer`

## Requirements
- R1: Within an event, the links that emit words appear in strictly ascending index order, starting with the lowest unmasked link. The next event starts again at the lowest unmasked link.
- R2: A link keeps the token until its trailer word (tag 2'b10) is consumed. If the next unmasked link already holds data, its first word is presented in the cycle right after that trailer. No cycle is spent on masked links in between.
- R3: A masked link holds `wr_ready` low, and none of its words ever appear on the output.
- R4: `out_last` is high together with the trailer of the highest-index unmasked link, and only on that word.
- R5: Words from successive events leave in the order in which they were written.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_tag`, `out_link`, `out_err` and `out_last` hold their values. After reset, `out_valid` is low.
- R7: With pairing off, each link accepts exactly LINK_DEPTH words before it lowers `wr_ready`. After reset, every unmasked link shows `wr_ready` high.
- R8: With `pair_en` high and exactly one link of a pair (2k, 2k+1) masked, the unmasked link accepts 2*LINK_DEPTH words and returns them in write order. With both links of a pair unmasked, `pair_en` has no effect on that pair.
- R9: If the first word a link emits for an event does not carry the header tag 2'b01, then that word and every later word of that link up to and including its trailer are flagged with `out_err`. The flag is clear again for the next link.
- R10: With every link masked, `out_valid` stays low and every write is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; empties all FIFOs and returns the token |
| link_mask | input | NUM_LINKS | Static mask; 1 takes the link out of use |
| pair_en | input | 1 | Static mode: lets a masked link lend its buffer to its pair partner |
| wr_valid | input | NUM_LINKS | Per-link input word valid |
| wr_tag | input | 2*NUM_LINKS | Per-link word tag, link i in bits [2i+1:2i] |
| wr_data | input | NUM_LINKS*DATA_W | Per-link word payload, link i in slice i |
| wr_ready | output | NUM_LINKS | Per-link input ready (FIFO not full and link unmasked) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | DATA_W | Output payload |
| out_tag | output | 2 | Tag of the output word |
| out_link | output | $clog2(NUM_LINKS) | Index of the link that supplied the word |
| out_err | output | 1 | Word belongs to a link that is in raw mode after a protocol error |
| out_last | output | 1 | Word is the final trailer of the event |

## Verification
The bench builds the block with four links of four words each and a 16-bit payload. With four links, two aligned pairs are present. That lets it test pairing in both directions (lower link lending and upper link lending) and show that pairing has no effect on a pair with both links active, all in one short run. A depth of four means that filling a link, or a doubled pair of eight, takes only a few writes. The fill also crosses the bank boundary inside a pair, so the extra address bit and its full flag are tested. With a masked link between two active links, the bench can confirm that the token skips that link without a gap cycle.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

  typedef enum logic [1:0] {
    TAG_DATA  = 2'b00,
    TAG_HEAD  = 2'b01,
    TAG_TRAIL = 2'b10,
    TAG_DATA2 = 2'b11
  } word_tag_e;

  function automatic logic tag_is_trailer(input logic [1:0] t);
    return t == TAG_TRAIL;
  endfunction

  function automatic logic tag_is_header(input logic [1:0] t);
    return t == TAG_HEAD;
  endfunction

endpackage

// File: rtl/tpr_pair_fifo.sv
module tpr_pair_fifo #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 34
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pair_en,
  input  logic [1:0]          mask,
  input  logic [1:0]          wr_valid,
  input  logic [2*WORD_W-1:0] wr_word,
  output logic [1:0]          wr_ready,
  input  logic [1:0]          rd_pop,
  output logic [1:0]          rd_avail,
  output logic [2*WORD_W-1:0] rd_word
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = AW + 2;
  localparam logic [PW-1:0] CAP_ONE = PW'(DEPTH);
  localparam logic [PW-1:0] CAP_TWO = PW'(2 * DEPTH);

  logic combined;
  logic lender_is_low;

  assign combined      = pair_en & (mask[0] ^ mask[1]);
  assign lender_is_low = mask[0];

  logic [WORD_W-1:0] mem [2][DEPTH];

  logic [PW-1:0] wptr  [2];
  logic [PW-1:0] rptr  [2];
  logic [PW-1:0] fill  [2];
  logic [PW-1:0] cap   [2];
  logic          owns  [2];
  logic          wbank [2];
  logic          rbank [2];
  logic          push  [2];
  logic          pop   [2];

  for (genvar j = 0; j < 2; j++) begin : g_side
    // the unmasked side of a lending pair owns both banks
    assign owns[j]  = combined && (lender_is_low == 1'(j));
    assign cap[j]   = owns[j] ? CAP_TWO : CAP_ONE;
    assign fill[j]  = wptr[j] - rptr[j];
    assign wr_ready[j] = !mask[j] && (fill[j] != cap[j]);
    assign rd_avail[j] = !mask[j] && (fill[j] != '0);
    assign wbank[j] = owns[j] ? wptr[j][AW] : 1'(j);
    assign rbank[j] = owns[j] ? rptr[j][AW] : 1'(j);
    assign push[j]  = wr_valid[j] && wr_ready[j];
    assign pop[j]   = rd_pop[j] && rd_avail[j];
    assign rd_word[j*WORD_W +: WORD_W] = mem[rbank[j]][rptr[j][AW-1:0]];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wptr[j] <= '0;
        rptr[j] <= '0;
      end else begin
        if (push[j]) wptr[j] <= wptr[j] + 1'b1;
        if (pop[j])  rptr[j] <= rptr[j] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < 2; j++) begin
      if (push[j]) mem[wbank[j]][wptr[j][AW-1:0]] <= wr_word[j*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/tpr_token_ring.sv
module tpr_token_ring
  import tpr_pkg::*;
#(
  parameter int NUM_LINKS = 8,
  parameter int LW        = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINKS-1:0] mask,
  input  logic                 pop,
  input  logic [1:0]           head_tag,
  output logic [LW-1:0]        cur_link,
  output logic                 any_active,
  output logic                 head_last,
  output logic                 head_err
);
  logic [LW-1:0] tok_q;
  logic          start_q;
  logic          seg_first_q;
  logic          raw_q;

  logic [LW-1:0] first_link;
  logic [LW-1:0] next_link;
  logic          has_next;

  always_comb begin
    first_link = '0;
    for (int i = NUM_LINKS - 1; i >= 0; i--) begin
      if (!mask[i]) first_link = LW'(i);
    end
  end

  assign any_active = ~&mask;
  assign cur_link   = start_q ? first_link : tok_q;

  always_comb begin
    next_link = '0;
    has_next  = 1'b0;
    for (int i = NUM_LINKS - 1; i >= 0; i--) begin
      if (!mask[i] && (LW'(i) > cur_link)) begin
        next_link = LW'(i);
        has_next  = 1'b1;
      end
    end
  end

  assign head_last = tag_is_trailer(head_tag) && !has_next;
  assign head_err  = raw_q || (seg_first_q && !tag_is_header(head_tag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_q       <= '0;
      start_q     <= 1'b1;
      seg_first_q <= 1'b1;
      raw_q       <= 1'b0;
    end else if (pop) begin
      if (tag_is_trailer(head_tag)) begin
        seg_first_q <= 1'b1;
        raw_q       <= 1'b0;
        if (has_next) begin
          tok_q   <= next_link;
          start_q <= 1'b0;
        end else begin
          start_q <= 1'b1;
        end
      end else begin
        seg_first_q <= 1'b0;
        if (seg_first_q && !tag_is_header(head_tag)) raw_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tpr_link_sequencer.sv
module tpr_link_sequencer #(
  parameter int NUM_LINKS  = 8,
  parameter int LINK_DEPTH = 16,
  parameter int DATA_W     = 32,
  localparam int LW        = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINKS-1:0]        link_mask,
  input  logic                        pair_en,
  input  logic [NUM_LINKS-1:0]        wr_valid,
  input  logic [2*NUM_LINKS-1:0]      wr_tag,
  input  logic [NUM_LINKS*DATA_W-1:0] wr_data,
  output logic [NUM_LINKS-1:0]        wr_ready,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [DATA_W-1:0]           out_data,
  output logic [1:0]                  out_tag,
  output logic [LW-1:0]               out_link,
  output logic                        out_err,
  output logic                        out_last
);
  localparam int WORD_W    = DATA_W + 2;
  localparam int NUM_PAIRS = NUM_LINKS / 2;

  logic [NUM_LINKS*WORD_W-1:0] in_words;
  logic [NUM_LINKS*WORD_W-1:0] head_words;
  logic [NUM_LINKS-1:0]        avail;
  logic [NUM_LINKS-1:0]        pop_vec;

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_pack
    assign in_words[i*WORD_W +: WORD_W] = {wr_tag[2*i +: 2], wr_data[i*DATA_W +: DATA_W]};
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    tpr_pair_fifo #(
      .DEPTH  (LINK_DEPTH),
      .WORD_W (WORD_W)
    ) pair_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pair_en  (pair_en),
      .mask     (link_mask[2*p +: 2]),
      .wr_valid (wr_valid[2*p +: 2]),
      .wr_word  (in_words[2*p*WORD_W +: 2*WORD_W]),
      .wr_ready (wr_ready[2*p +: 2]),
      .rd_pop   (pop_vec[2*p +: 2]),
      .rd_avail (avail[2*p +: 2]),
      .rd_word  (head_words[2*p*WORD_W +: 2*WORD_W])
    );
  end

  logic [LW-1:0]     cur;
  logic              any_active;
  logic              head_last;
  logic              head_err;
  logic [WORD_W-1:0] head;
  logic              fire;

  assign head      = head_words[cur*WORD_W +: WORD_W];
  assign out_valid = any_active && avail[cur];
  assign fire      = out_valid && out_ready;
  assign pop_vec   = fire ? (NUM_LINKS'(1) << cur) : '0;

  tpr_token_ring #(
    .NUM_LINKS (NUM_LINKS),
    .LW        (LW)
  ) ring_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask       (link_mask),
    .pop        (fire),
    .head_tag   (head[WORD_W-1 -: 2]),
    .cur_link   (cur),
    .any_active (any_active),
    .head_last  (head_last),
    .head_err   (head_err)
  );

  assign out_data = head[DATA_W-1:0];
  assign out_tag  = head[WORD_W-1 -: 2];
  assign out_link = cur;
  assign out_err  = out_valid && head_err;
  assign out_last = out_valid && head_last;

endmodule

// File: rtl/tpr_link_sequencer_chk.sv
module tpr_link_sequencer_chk #(
  parameter int NUM_LINKS = 8,
  parameter int DATA_W    = 32,
  parameter int LW        = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINKS-1:0] link_mask,
  input logic [NUM_LINKS-1:0] wr_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [DATA_W-1:0]    out_data,
  input logic [1:0]           out_tag,
  input logic [LW-1:0]        out_link,
  input logic                 out_err,
  input logic                 out_last
);
  logic fire;
  assign fire = out_valid && out_ready;

  // R3: a masked link never supplies an output word
  p_masked_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !link_mask[out_link]);

  // R3: a masked link never accepts a word
  p_masked_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mask & wr_ready) == '0);

  // R6: output frozen under back-pressure
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)
                                   && $stable(out_link) && $stable(out_err) && $stable(out_last)));

  // R2: token stays on a link until its trailer is consumed
  p_token_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_tag != 2'b10) |=> out_link == $past(out_link));

  // R1: after a non-final trailer the token only moves upward
  p_ascend_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_tag == 2'b10 && !out_last) |=> out_link > $past(out_link));

  // R4: end-of-event mark only on a trailer word
  p_last_on_trailer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_tag == 2'b10));

  // R10: nothing leaves when every link is masked
  p_all_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (&link_mask) |-> !out_valid);

endmodule

bind tpr_link_sequencer tpr_link_sequencer_chk #(
  .NUM_LINKS (NUM_LINKS),
  .DATA_W    (DATA_W),
  .LW        (LW)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .link_mask (link_mask),
  .wr_ready  (wr_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_tag   (out_tag),
  .out_link  (out_link),
  .out_err   (out_err),
  .out_last  (out_last)
);

// File: tb/tpr_link_sequencer_tb_top.sv
`timescale 1ns/1ps
module tpr_link_sequencer_tb_top;
  localparam int NL = 4;
  localparam int DP = 4;
  localparam int DW = 16;
  localparam int LW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NL-1:0]   link_mask = '0;
  logic            pair_en = 1'b0;
  logic [NL-1:0]   wr_valid = '0;
  logic [2*NL-1:0] wr_tag = '0;
  logic [NL*DW-1:0] wr_data = '0;
  logic [NL-1:0]   wr_ready;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [DW-1:0]   out_data;
  logic [1:0]      out_tag;
  logic [LW-1:0]   out_link;
  logic            out_err;
  logic            out_last;

  always #2.5 clk = ~clk;

  tpr_link_sequencer #(.NUM_LINKS(NL), .LINK_DEPTH(DP), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .link_mask(link_mask), .pair_en(pair_en),
    .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_data(wr_data), .wr_ready(wr_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_tag(out_tag),
    .out_link(out_link), .out_err(out_err), .out_last(out_last)
  );

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  // row: {link[21:20], tag[19:18], data[17:2], err[1], last[0]}
  localparam int ROWS = 8;
  localparam logic [21:0] TBL [ROWS] = '{
    {2'd0, 2'b01, 16'h0A01, 1'b0, 1'b0},
    {2'd0, 2'b00, 16'h0A02, 1'b0, 1'b0},
    {2'd0, 2'b10, 16'h0A03, 1'b0, 1'b0},
    {2'd1, 2'b00, 16'h1B01, 1'b1, 1'b0},
    {2'd1, 2'b11, 16'h1B02, 1'b1, 1'b0},
    {2'd1, 2'b10, 16'h1B03, 1'b1, 1'b0},
    {2'd3, 2'b01, 16'h3C01, 1'b0, 1'b0},
    {2'd3, 2'b10, 16'h3C02, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [NL-1:0] m, input logic pe);
    @(negedge clk);
    rst_n = 1'b0; link_mask = m; pair_en = pe; wr_valid = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // starts and ends on a falling edge
  task automatic write_word(input int l, input logic [1:0] t, input logic [DW-1:0] d,
                            output bit acc);
    wr_valid = '0;
    wr_valid[l] = 1'b1;
    wr_tag[2*l +: 2] = t;
    wr_data[l*DW +: DW] = d;
    #1 acc = wr_ready[l];
    @(negedge clk);
    wr_valid = '0;
  endtask

  task automatic fill_count(input int l, output int n);
    bit acc;
    n = 0;
    for (int k = 0; k < 12; k++) begin
      write_word(l, 2'b00, DW'(k), acc);
      if (acc) n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bit acc;
    int n;
    int lasts;

    // reset state
    do_reset('0, 1'b0);
    #1;
    check(out_valid == 1'b0, "R6", "out_valid after reset", out_valid, 0);
    check(wr_ready == 4'b1111, "R7", "wr_ready after reset", wr_ready, 4'hF);

    // table-driven event: link 2 masked, links loaded top-down
    do_reset(4'b0100, 1'b0);
    #1 check(wr_ready == 4'b1011, "R3", "wr_ready with link2 masked", wr_ready, 4'hB);
    @(negedge clk);
    write_word(2, 2'b01, 16'hDEAD, acc);
    check(acc == 1'b0, "R3", "write to masked link accepted", acc, 0);
    for (int l = NL - 1; l >= 0; l--)
      for (int r = 0; r < ROWS; r++)
        if (int'(TBL[r][21:20]) == l) write_word(l, TBL[r][19:18], TBL[r][17:2], acc);
    out_ready = 1'b1;
    for (int r = 0; r < ROWS; r++) begin
      #1;
      check(out_valid == 1'b1, "R2", $sformatf("row %0d valid, no gap", r), out_valid, 1);
      check(out_link == TBL[r][21:20], "R1", $sformatf("row %0d link", r), out_link, TBL[r][21:20]);
      check(out_data == TBL[r][17:2], "R5", $sformatf("row %0d data", r), out_data, TBL[r][17:2]);
      check(out_err == TBL[r][1], "R9", $sformatf("row %0d err", r), out_err, TBL[r][1]);
      check(out_last == TBL[r][0], "R4", $sformatf("row %0d last", r), out_last, TBL[r][0]);
      @(negedge clk);
    end
    #1 check(out_valid == 1'b0, "R3", "nothing left after event", out_valid, 0);

    // back-pressure hold
    do_reset('0, 1'b0);
    @(negedge clk);
    write_word(0, 2'b01, 16'h5A5A, acc);
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b1 && out_data == 16'h5A5A, "R6", "held word", out_data, 16'h5A5A);
    check(out_link == 2'd0, "R6", "held link", out_link, 0);

    // single-link depth
    do_reset('0, 1'b0);
    @(negedge clk);
    fill_count(1, n);
    check(n == DP, "R7", "depth link1 no pairing", n, DP);

    // pairing ignored when both links active
    do_reset('0, 1'b1);
    @(negedge clk);
    fill_count(0, n);
    check(n == DP, "R8", "depth link0 pair_en, partner active", n, DP);

    // lower link borrows upper buffer
    do_reset(4'b1110, 1'b1);
    @(negedge clk);
    for (int k = 0; k < 2 * DP; k++) begin
      write_word(0, (k == 2 * DP - 1) ? 2'b10 : 2'b00, DW'(16'h100 + k), acc);
      check(acc == 1'b1, "R8", $sformatf("paired write %0d", k), acc, 1);
    end
    #1 check(wr_ready[0] == 1'b0, "R8", "paired full", wr_ready[0], 0);
    @(negedge clk);
    out_ready = 1'b1;
    for (int k = 0; k < 2 * DP; k++) begin
      #1;
      check(out_valid && out_data == DW'(16'h100 + k), "R8", $sformatf("paired read %0d", k),
            out_data, 16'h100 + k);
      check(out_last == (k == 2 * DP - 1), "R4", $sformatf("paired last %0d", k), out_last,
            (k == 2 * DP - 1));
      @(negedge clk);
    end

    // upper link borrows lower buffer
    do_reset(4'b1101, 1'b1);
    @(negedge clk);
    fill_count(1, n);
    check(n == 2 * DP, "R8", "depth link1 with link0 lending", n, 2 * DP);

    // all links masked
    do_reset(4'b1111, 1'b0);
    @(negedge clk);
    out_ready = 1'b1;
    n = 0;
    for (int l = 0; l < NL; l++) begin
      write_word(l, 2'b01, 16'h7777, acc);
      if (acc) n++;
    end
    #1;
    check(n == 0, "R10", "writes accepted with all masked", n, 0);
    check(out_valid == 1'b0, "R10", "out_valid with all masked", out_valid, 0);

    // two events back to back
    do_reset('0, 1'b0);
    @(negedge clk);
    for (int l = 0; l < NL; l++)
      for (int e = 0; e < 2; e++) begin
        write_word(l, 2'b01, {4'(e), 4'(l), 8'h00}, acc);
        write_word(l, 2'b10, {4'(e), 4'(l), 8'h01}, acc);
      end
    out_ready = 1'b1;
    lasts = 0;
    for (int e = 0; e < 2; e++)
      for (int l = 0; l < NL; l++)
        for (int k = 0; k < 2; k++) begin
          #1;
          check(out_valid && out_data == {4'(e), 4'(l), 8'(k)}, "R5",
                $sformatf("event %0d link %0d word %0d", e, l, k), out_data, {4'(e), 4'(l), 8'(k)});
          check(out_link == LW'(l), "R1", $sformatf("event %0d link order", e), out_link, l);
          if (out_last) lasts++;
          @(negedge clk);
        end
    check(lasts == 2, "R4", "end-of-event marks over two events", lasts, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule